// File: doc/BRIEF.md
# Flash Command Status and Launch Register

This block sits between a CPU register port and a flash command engine. It keeps one 8-bit status word with five live bits: a command-complete flag, three error flags that software clears by writing 1 (read collision, access error, protection violation), and an execution-error status bit that software cannot write. Software starts a command by writing 1 to the complete flag. The block then sends the engine a one-cycle launch pulse and holds the complete flag low until the engine reports that the command ended.

The engine reports back on plain input strobes: end of its reset initialisation, command done, execution error, sequence violation, protection violation and collision. A CPU read of the flash array while a command is running also counts as a collision. A pending access or protection error blocks any launch.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset the status word reads 0x00. A pulse on engInitDone sets bit 7 (complete flag) to 1.
- R2: The status word is bit 7 complete, bit 6 read collision, bit 5 access error, bit 4 protection violation and bit 0 execution error. It appears on regRdData the cycle after the edge that updates it.
- R3: A write with bit 7 = 1, while bit 7 is 1 and bits 5 and 4 are 0, clears bit 7 and raises launchPulse for exactly one cycle, starting the cycle after the write. The same write while bit 7 is 0 does nothing.
- R4: While bit 5 or bit 4 is set, a write with bit 7 = 1 gives no launch pulse and bit 7 stays 1.
- R5: engDone, engSeqViol or engProtViol returns bit 7 to 1.
- R6: Bit 6 sets on engCollision, or on cpuFlashRd while bit 7 is 0. cpuFlashRd while bit 7 is 1 has no effect.
- R7: engSeqViol sets bit 5. engProtViol sets bit 4.
- R8: Writing 1 to bit 6, 5 or 4 clears that bit. Writing 0 leaves it unchanged.
- R9: When a set event and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R10: Bits 3..1 always read 0, and writes to them change nothing.
- R11: Bit 0 sets when engErr is high together with engDone or engInitDone. Register writes never change it.
- R12: Bit 0 clears on the edge that ends the launch pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Status register write strobe |
| regWrData | input | 8 | Status register write data |
| cpuFlashRd | input | 1 | CPU read of the flash array this cycle |
| engInitDone | input | 1 | Engine finished its reset initialisation |
| engDone | input | 1 | Engine finished the running command |
| engErr | input | 1 | Execution error, qualified by engDone or engInitDone |
| engSeqViol | input | 1 | Engine flagged a command sequence violation |
| engProtViol | input | 1 | Engine flagged a program or erase to a protected address |
| engCollision | input | 1 | Engine detected a collision on its resource |
| regRdData | output | 8 | Status register read value |
| launchPulse | output | 1 | One-cycle command start to the engine |

## Verification
Two functions can act on the same flag in one cycle. A hardware set (violation or collision) can meet a software write-1 clear. A launch request can meet an error flag that the same write is clearing. The bench drives each pair in a single cycle: a write-1 clear together with engSeqViol or engCollision, and a launch write that also clears the blocking protection flag. A scoreboard judges the result: the flag must stay set in the first case, and in the second no pulse may appear while the flag still clears.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int REG_W     = 8;
  localparam int CCIF_BIT  = 7;
  localparam int RDCOL_BIT = 6;
  localparam int ACC_BIT   = 5;
  localparam int PROT_BIT  = 4;
  localparam int MG_BIT    = 0;

  typedef struct packed {
    logic launchAcc;
    logic setRdCol;
    logic clrRdCol;
    logic setAcc;
    logic clrAcc;
    logic setProt;
    logic clrProt;
    logic setMg;
    logic clrMg;
  } statStrobes_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import flash_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [W-1:0] regWrData,
  input  logic         cpuFlashRd,
  input  logic         engInitDone,
  input  logic         engDone,
  input  logic         engErr,
  input  logic         engSeqViol,
  input  logic         engProtViol,
  input  logic         engCollision,
  input  logic         accErr,
  input  logic         protErr,
  output logic         ccif,
  output logic         launchPulse,
  output statStrobes_t st
);
  logic wantLaunch, cmdEnd, launchOk;

  assign wantLaunch = regWrEn && regWrData[CCIF_BIT];
  assign cmdEnd     = engInitDone || engDone || engSeqViol || engProtViol;
  assign launchOk   = wantLaunch && ccif && !accErr && !protErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccif        <= 1'b0;
      launchPulse <= 1'b0;
    end else begin
      launchPulse <= launchOk;
      if (cmdEnd)        ccif <= 1'b1;
      else if (launchOk) ccif <= 1'b0;
    end
  end

  always_comb begin
    st           = '0;
    st.launchAcc = launchOk;
    st.setRdCol  = engCollision || (cpuFlashRd && !ccif);
    st.clrRdCol  = regWrEn && regWrData[RDCOL_BIT];
    st.setAcc    = engSeqViol;
    st.clrAcc    = regWrEn && regWrData[ACC_BIT];
    st.setProt   = engProtViol;
    st.clrProt   = regWrEn && regWrData[PROT_BIT];
    st.setMg     = engErr && (engDone || engInitDone);
    st.clrMg     = launchPulse;
  end

  // R3: an accepted launch gives one pulse and drops the complete flag
  a_r3_launch_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wantLaunch && ccif && !accErr && !protErr && !cmdEnd) |=> (launchPulse && !ccif));
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    launchPulse |=> !launchPulse);
  // R4: a pending error blocks the launch
  a_r4_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (wantLaunch && (accErr || protErr)) |=> !launchPulse);
  // R5: any command end raises the complete flag
  a_r5_end_sets: assert property (@(posedge clk) disable iff (!rstN)
    cmdEnd |=> ccif);
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import flash_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  statStrobes_t st,
  input  logic         ccif,
  output logic         accErr,
  output logic         protErr,
  output logic [W-1:0] regRdData
);
  logic rdCol, mgStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCol   <= 1'b0;
      accErr  <= 1'b0;
      protErr <= 1'b0;
      mgStat  <= 1'b0;
    end else begin
      if (st.setRdCol)      rdCol <= 1'b1;
      else if (st.clrRdCol) rdCol <= 1'b0;
      if (st.setAcc)        accErr <= 1'b1;
      else if (st.clrAcc)   accErr <= 1'b0;
      if (st.setProt)       protErr <= 1'b1;
      else if (st.clrProt)  protErr <= 1'b0;
      if (st.setMg)         mgStat <= 1'b1;
      else if (st.clrMg)    mgStat <= 1'b0;
    end
  end

  always_comb begin
    regRdData            = '0;
    regRdData[CCIF_BIT]  = ccif;
    regRdData[RDCOL_BIT] = rdCol;
    regRdData[ACC_BIT]   = accErr;
    regRdData[PROT_BIT]  = protErr;
    regRdData[MG_BIT]    = mgStat;
  end

  // R8: write-1 clear takes effect when no set competes
  a_r8_w1c_acc: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrAcc && !st.setAcc) |=> !accErr);
  // R9: a set beats a simultaneous clear
  a_r9_set_wins_rdcol: assert property (@(posedge clk) disable iff (!rstN)
    (st.setRdCol && st.clrRdCol) |=> rdCol);
  a_r9_set_wins_prot: assert property (@(posedge clk) disable iff (!rstN)
    (st.setProt && st.clrProt) |=> protErr);
  // R12: execution status drops after the launch pulse
  a_r12_mg_clear: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrMg && !st.setMg) |=> !mgStat);
  // R11: only an error report raises execution status
  a_r11_mg_source: assert property (@(posedge clk) disable iff (!rstN)
    (!st.setMg && !mgStat) |=> !mgStat);
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [W-1:0] regWrData,
  input  logic         cpuFlashRd,
  input  logic         engInitDone,
  input  logic         engDone,
  input  logic         engErr,
  input  logic         engSeqViol,
  input  logic         engProtViol,
  input  logic         engCollision,
  output logic [W-1:0] regRdData,
  output logic         launchPulse
);
  statStrobes_t st;
  logic ccif, accErr, protErr;

  fsc_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .cpuFlashRd(cpuFlashRd), .engInitDone(engInitDone), .engDone(engDone),
    .engErr(engErr), .engSeqViol(engSeqViol), .engProtViol(engProtViol),
    .engCollision(engCollision), .accErr(accErr), .protErr(protErr),
    .ccif(ccif), .launchPulse(launchPulse), .st(st)
  );

  fsc_datapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .ccif(ccif),
    .accErr(accErr), .protErr(protErr), .regRdData(regRdData)
  );

  // R10: reserved field reads zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[3:1] == 3'b000));
endmodule

// File: tb/flash_cmd_status_tb.sv
module flash_cmd_status_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, cpuFlashRd = 0, engInitDone = 0, engDone = 0, engErr = 0;
  logic engSeqViol = 0, engProtViol = 0, engCollision = 0;
  logic [7:0] regWrData = '0, regRdData;
  logic launchPulse;

  flash_cmd_status dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .cpuFlashRd(cpuFlashRd), .engInitDone(engInitDone), .engDone(engDone),
    .engErr(engErr), .engSeqViol(engSeqViol), .engProtViol(engProtViol),
    .engCollision(engCollision), .regRdData(regRdData), .launchPulse(launchPulse)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       ln;
  } item_t;
  item_t q[$];

  int total = 0, failed = 0;
  bit done = 0;
  logic mC = 0, mRc = 0, mAcc = 0, mPr = 0, mMg = 0, mLn = 0;

  task automatic doOp(string tag, logic wr, logic [7:0] wd, logic rd, logic ini,
                      logic dn, logic er, logic sv, logic pv, logic ec);
    logic ok, prevLn;
    item_t it;
    @(negedge clk);
    regWrEn = wr; regWrData = wd; cpuFlashRd = rd; engInitDone = ini;
    engDone = dn; engErr = er; engSeqViol = sv; engProtViol = pv; engCollision = ec;
    prevLn = mLn;
    ok = wr && wd[7] && mC && !mAcc && !mPr;
    if (ec || (rd && !mC)) mRc = 1; else if (wr && wd[6]) mRc = 0;
    if (sv) mAcc = 1; else if (wr && wd[5]) mAcc = 0;
    if (pv) mPr = 1; else if (wr && wd[4]) mPr = 0;
    if (er && (dn || ini)) mMg = 1; else if (prevLn) mMg = 0;
    if (ini || dn || sv || pv) mC = 1; else if (ok) mC = 0;
    mLn = ok;
    it.tag = tag; it.rd = {mC, mRc, mAcc, mPr, 3'b000, mMg}; it.ln = mLn;
    q.push_back(it);
  endtask

  // monitor: compare after the edge following each push
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (regRdData !== it.rd || launchPulse !== it.ln) begin
          failed++;
          $display("FAIL %s: got rd=%02h launch=%0b, expected rd=%02h launch=%0b",
                   it.tag, regRdData, launchPulse, it.rd, it.ln);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doOp("R1 reset state",               0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    doOp("R1 R11 init done with error",  0, 8'h00, 0, 1, 0, 1, 0, 0, 0);
    doOp("R11 write cannot clear bit0",  1, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    doOp("R10 reserved write ignored",   1, 8'h0E, 0, 0, 0, 0, 0, 0, 0);
    doOp("R3 launch accepted",           1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R12 bit0 clears after pulse",  0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    doOp("R3 launch while busy ignored", 1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R6 read while busy collides",  0, 8'h00, 1, 0, 0, 0, 0, 0, 0);
    doOp("R5 R11 done with error",       0, 8'h00, 0, 0, 1, 1, 0, 0, 0);
    doOp("R8 write zero no effect",      1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    doOp("R8 clear collision",           1, 8'h40, 0, 0, 0, 0, 0, 0, 0);
    doOp("R6 read while idle no effect", 0, 8'h00, 1, 0, 0, 0, 0, 0, 0);
    doOp("R3 second launch",             1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R7 R5 sequence violation",     0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
    doOp("R4 launch blocked by access",  1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R9 set beats clear on access", 1, 8'h20, 0, 0, 0, 0, 1, 0, 0);
    doOp("R8 clear access error",        1, 8'h20, 0, 0, 0, 0, 0, 0, 0);
    doOp("R3 third launch",              1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R7 R5 protection violation",   0, 8'h00, 0, 0, 0, 0, 0, 1, 0);
    doOp("R4 blocked launch with clear", 1, 8'h90, 0, 0, 0, 0, 0, 0, 0);
    doOp("R6 engine collision",          0, 8'h00, 0, 0, 0, 0, 0, 0, 1);
    doOp("R9 set beats clear collision", 1, 8'h40, 0, 0, 0, 0, 0, 0, 1);
    doOp("R8 clear all error flags",     1, 8'h70, 0, 0, 0, 0, 0, 0, 0);
    doOp("R3 fourth launch",             1, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    doOp("R5 R2 clean done",             0, 8'h00, 0, 0, 1, 0, 0, 0, 0);
    doOp("R2 idle hold",                 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule